// File: doc/BRIEF.md
# Hierarchical Coherence Directory Controller

This block is one node of a tree of split-transaction buses that keeps shared items coherent without any backing memory. It holds only per-item coherence state for everything cached in the subtree beneath it, never the data itself. Its job is to filter traffic in both directions. A request from the lower bus goes up only when the subtree cannot satisfy it. A request from the upper bus goes down only when the subtree has to service it. While a request is outstanding, the directory leaves a transient state on the item: reading, waiting for an erase acknowledge, or promising an answer. The reply later follows that trail back, and a second read that meets the trail is absorbed.

Two transaction streams enter the block. The upper bus snoop is atomic and always wins arbitration. The lower stream is drawn from an input buffer whenever the lookup is free and both output queues have room. Each accepted transaction causes at most one outgoing transaction. That transaction goes into the upward queue or the downward queue. Every stream port is valid/ready. An input transfers on a clock edge where valid and ready are both high. An output holds its op and id steady while valid is high and ready is low. When either output queue is full, the block lowers both input readys.

Top module: `hier_dir_ctrl`

## Requirements
- R1: After reset every item reads as invalid: both output valids are low, both input readys are high, and a read from above raises no bid.
- R2: A read from below (op 0) for an item in invalid is sent upward as a read, and the item enters reading.
- R3: A read from either side that finds the item in reading or answering is absorbed: nothing is emitted, no bid is raised and the state is kept.
- R4: An erase from below (op 2) for an exclusive item returns an exclusive acknowledge (op 3) downward, and the state stays exclusive. For a shared item, the erase goes upward and the item enters waiting.
- R5: A read from above for an item in exclusive or shared raises `up_bid` in the same cycle. If `up_in_sel` is high, the item enters answering and the read is reissued downward. If it is low, nothing changes.
- R6: Data (op 1) from below for an item in answering goes upward. Data from above for an item in reading goes downward. In both cases the item becomes shared.
- R7: An exclusive acknowledge from above for an item in waiting is passed downward, and the item becomes exclusive.
- R8: An erase from above for an item in shared, exclusive, waiting or answering is reissued downward, and the item becomes invalid. For an item in invalid or reading it has no effect.
- R9: An out (op 4) from below for a shared item is answered downward with data when `lo_in_bid` is high, and the state stays shared. Otherwise the out goes upward and the item becomes invalid.
- R10: An upper transaction that is present blocks the lower input. A full output queue lowers both input readys. Queued outputs leave in order and hold steady under back-pressure. Every op and state pairing not listed in R2 to R9 is accepted with no output and no state change.
- R11: Each set keeps up to eight items independently, with the set index taken from the low id bits. An item with no entry behaves as invalid and takes no entry when its state stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_in_valid | input | 1 | Lower input buffer has a transaction |
| lo_in_ready | output | 1 | Lower transaction taken this edge |
| lo_in_op | input | 3 | Lower op: 0 read, 1 data, 2 erase, 3 exclusive, 4 out |
| lo_in_id | input | ID_W | Lower item id |
| lo_in_bid | input | 1 | Another subsystem bid on this out |
| up_in_valid | input | 1 | Upper bus snoop transaction present |
| up_in_ready | output | 1 | Upper transaction taken this edge |
| up_in_op | input | 3 | Upper op, same coding |
| up_in_id | input | ID_W | Upper item id |
| up_in_sel | input | 1 | This node was selected for the present read |
| up_bid | output | 1 | Priority-1 bid for the present upper read |
| up_out_valid | output | 1 | Upward queue head valid |
| up_out_ready | input | 1 | Upper bus takes the head |
| up_out_op | output | 3 | Upward op |
| up_out_id | output | ID_W | Upward item id |
| lo_out_valid | output | 1 | Downward queue head valid |
| lo_out_ready | input | 1 | Lower bus takes the head |
| lo_out_op | output | 3 | Downward op |
| lo_out_id | output | ID_W | Downward item id |

## Verification
The state table is swept by a long pseudo-random stream of ops from both sides. The stream runs over 32 items that fill all eight ways of four sets, and the select and bid flags are toggled at random. Every output and bid is compared against a model kept from the requirement table. This separates correct transitions from wrong next states, because a wrong state shows up later as a wrong or missing forward. Directed patterns stall the upward queue to full and then drain it, which exposes ordering and ready gating. They also present both inputs at once to show that the upper side wins. Probes of untouched ids in a full set show that missing entries behave as invalid.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_DATA  = 3'd1,
    OP_ERASE = 3'd2,
    OP_EXCL  = 3'd3,
    OP_OUT   = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    ST_I = 4'd0,
    ST_E = 4'd1,
    ST_S = 4'd2,
    ST_R = 4'd3,
    ST_W = 4'd4,
    ST_A = 4'd5
  } st_e;

  typedef struct packed {
    logic up_en;
    op_e  up_op;
    logic dn_en;
    op_e  dn_op;
    st_e  nxt;
  } act_t;
endpackage

// File: rtl/dir_fifo.sv
module dir_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic pop;

  assign pop       = out_valid && out_ready;
  assign out_valid = (cnt_q != '0);
  assign full      = (cnt_q == (PW+1)'(DEPTH));
  assign dout      = mem[rp_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout)));
endmodule

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int ID_W     = 8,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] id,
  output st_e             cur_st,
  input  logic            we,
  input  st_e             wr_st
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ID_W - SET_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  st_e             st_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  logic [SET_BITS-1:0] set_idx;
  logic [TAG_W-1:0]    tag;
  logic [WAYS-1:0]     hit_vec, free_vec;
  logic [WAY_W-1:0]    hit_way, free_way;
  logic                hit, has_free;

  assign set_idx = id[SET_BITS-1:0];
  assign tag     = id[ID_W-1:SET_BITS];

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      free_vec[w] = (st_q[set_idx][w] == ST_I);
      hit_vec[w]  = !free_vec[w] && (tag_q[set_idx][w] == tag);
    end
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = w[WAY_W-1:0];
      if (free_vec[w]) free_way = w[WAY_W-1:0];
    end
    hit      = |hit_vec;
    has_free = |free_vec;
    cur_st   = hit ? st_q[set_idx][hit_way] : ST_I;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          st_q[s][w] <= ST_I;
    end else if (we) begin
      if (hit)
        st_q[set_idx][hit_way] <= wr_st;
      else if (wr_st != ST_I && has_free)
        st_q[set_idx][free_way] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !hit && wr_st != ST_I && has_free)
      tag_q[set_idx][free_way] <= tag;
  end

  a_r11_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1);

  a_r11_room: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit && wr_st != ST_I) |-> has_free);
endmodule

// File: rtl/dir_proto.sv
module dir_proto
  import dir_pkg::*;
(
  input  logic from_above,
  input  op_e  op,
  input  st_e  cur,
  input  logic sel,
  input  logic other_bid,
  output act_t act
);
  always_comb begin
    act.up_en = 1'b0;
    act.up_op = OP_READ;
    act.dn_en = 1'b0;
    act.dn_op = OP_READ;
    act.nxt   = cur;
    if (from_above) begin
      unique case (op)
        OP_READ:
          if ((cur == ST_E || cur == ST_S) && sel) begin
            act.nxt = ST_A; act.dn_en = 1'b1; act.dn_op = OP_READ;
          end
        OP_DATA:
          if (cur == ST_R) begin
            act.nxt = ST_S; act.dn_en = 1'b1; act.dn_op = OP_DATA;
          end
        OP_EXCL:
          if (cur == ST_W) begin
            act.nxt = ST_E; act.dn_en = 1'b1; act.dn_op = OP_EXCL;
          end
        OP_ERASE:
          if (cur == ST_S || cur == ST_E || cur == ST_W || cur == ST_A) begin
            act.nxt = ST_I; act.dn_en = 1'b1; act.dn_op = OP_ERASE;
          end
        default: ;
      endcase
    end else begin
      unique case (op)
        OP_READ:
          if (cur == ST_I) begin
            act.nxt = ST_R; act.up_en = 1'b1; act.up_op = OP_READ;
          end
        OP_ERASE:
          if (cur == ST_E) begin
            act.dn_en = 1'b1; act.dn_op = OP_EXCL;
          end else if (cur == ST_S) begin
            act.nxt = ST_W; act.up_en = 1'b1; act.up_op = OP_ERASE;
          end
        OP_DATA:
          if (cur == ST_A) begin
            act.nxt = ST_S; act.up_en = 1'b1; act.up_op = OP_DATA;
          end
        OP_OUT:
          if (cur == ST_S) begin
            if (other_bid) begin
              act.dn_en = 1'b1; act.dn_op = OP_DATA;
            end else begin
              act.nxt = ST_I; act.up_en = 1'b1; act.up_op = OP_OUT;
            end
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hier_dir_ctrl.sv
module hier_dir_ctrl
  import dir_pkg::*;
#(
  parameter int ID_W       = 8,
  parameter int SET_BITS   = 2,
  parameter int WAYS       = 8,
  parameter int OBUF_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_in_valid,
  output logic            lo_in_ready,
  input  logic [2:0]      lo_in_op,
  input  logic [ID_W-1:0] lo_in_id,
  input  logic            lo_in_bid,
  input  logic            up_in_valid,
  output logic            up_in_ready,
  input  logic [2:0]      up_in_op,
  input  logic [ID_W-1:0] up_in_id,
  input  logic            up_in_sel,
  output logic            up_bid,
  output logic            up_out_valid,
  input  logic            up_out_ready,
  output logic [2:0]      up_out_op,
  output logic [ID_W-1:0] up_out_id,
  output logic            lo_out_valid,
  input  logic            lo_out_ready,
  output logic [2:0]      lo_out_op,
  output logic [ID_W-1:0] lo_out_id
);
  localparam int TW = 3 + ID_W;

  logic            up_full, lo_full, space, take;
  logic [ID_W-1:0] cur_id;
  op_e             cur_op;
  st_e             cur_st;
  act_t            act;
  logic [TW-1:0]   up_dout, lo_dout;

  assign space       = !up_full && !lo_full;
  assign up_in_ready = space;
  assign lo_in_ready = space && !up_in_valid;
  assign take        = (up_in_valid || lo_in_valid) && space;
  assign cur_id      = up_in_valid ? up_in_id : lo_in_id;
  assign cur_op      = op_e'(up_in_valid ? up_in_op : lo_in_op);
  assign up_bid      = up_in_valid && (op_e'(up_in_op) == OP_READ) &&
                       (cur_st == ST_E || cur_st == ST_S);

  dir_store #(.ID_W(ID_W), .SET_BITS(SET_BITS), .WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_n), .id(cur_id), .cur_st(cur_st),
    .we(take), .wr_st(act.nxt)
  );

  dir_proto u_proto (
    .from_above(up_in_valid), .op(cur_op), .cur(cur_st),
    .sel(up_in_sel), .other_bid(lo_in_bid), .act(act)
  );

  dir_fifo #(.DEPTH(OBUF_DEPTH), .W(TW)) u_upq (
    .clk(clk), .rst_n(rst_n), .push(take && act.up_en),
    .din({act.up_op, cur_id}), .full(up_full),
    .out_valid(up_out_valid), .out_ready(up_out_ready), .dout(up_dout)
  );

  dir_fifo #(.DEPTH(OBUF_DEPTH), .W(TW)) u_loq (
    .clk(clk), .rst_n(rst_n), .push(take && act.dn_en),
    .din({act.dn_op, cur_id}), .full(lo_full),
    .out_valid(lo_out_valid), .out_ready(lo_out_ready), .dout(lo_dout)
  );

  assign up_out_op = up_dout[TW-1:ID_W];
  assign up_out_id = up_dout[ID_W-1:0];
  assign lo_out_op = lo_dout[TW-1:ID_W];
  assign lo_out_id = lo_dout[ID_W-1:0];

  a_r10_lower_yield: assert property (@(posedge clk) disable iff (!rst_n)
    up_in_valid |-> !lo_in_ready);

  a_r5_bid_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    up_bid |-> (up_in_valid && up_in_op == 3'd0));

  a_r3_single_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && act.up_en && act.dn_en));
endmodule

// File: tb/hier_dir_ctrl_test.sv
module hier_dir_ctrl_test;
  localparam int ID_W = 8;
  localparam int NI   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_in_valid = 0, lo_in_bid = 0, up_in_valid = 0, up_in_sel = 0;
  logic [2:0] lo_in_op = 0, up_in_op = 0;
  logic [ID_W-1:0] lo_in_id = 0, up_in_id = 0;
  logic up_out_ready = 1, lo_out_ready = 1;
  logic lo_in_ready, up_in_ready, up_bid, up_out_valid, lo_out_valid;
  logic [2:0] up_out_op, lo_out_op;
  logic [ID_W-1:0] up_out_id, lo_out_id;

  int nchk = 0, nfail = 0;
  int mst [NI];

  always #2.5 clk = ~clk;

  hier_dir_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .lo_in_valid(lo_in_valid), .lo_in_ready(lo_in_ready), .lo_in_op(lo_in_op),
    .lo_in_id(lo_in_id), .lo_in_bid(lo_in_bid),
    .up_in_valid(up_in_valid), .up_in_ready(up_in_ready), .up_in_op(up_in_op),
    .up_in_id(up_in_id), .up_in_sel(up_in_sel), .up_bid(up_bid),
    .up_out_valid(up_out_valid), .up_out_ready(up_out_ready),
    .up_out_op(up_out_op), .up_out_id(up_out_id),
    .lo_out_valid(lo_out_valid), .lo_out_ready(lo_out_ready),
    .lo_out_op(lo_out_op), .lo_out_id(lo_out_id)
  );

  // state codes: 0 I, 1 E, 2 S, 3 R, 4 W, 5 A
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lo_in_valid = 0; up_in_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NI; i++) mst[i] = 0;
  endtask

  // model from the requirement table
  task automatic model(input bit above, input int op, input int st,
                       input bit flag, output int ue, output int uo,
                       output int de, output int dop, output int nx,
                       output string req);
    ue = 0; uo = 0; de = 0; dop = 0; nx = st; req = "R10";
    if (above) begin
      case (op)
        0: if (st == 1 || st == 2) begin
             req = "R5"; if (flag) begin nx = 5; de = 1; dop = 0; end
           end else if (st == 3 || st == 5) req = "R3";
        1: if (st == 3) begin req = "R6"; nx = 2; de = 1; dop = 1; end
        3: if (st == 4) begin req = "R7"; nx = 1; de = 1; dop = 3; end
        2: begin
             req = "R8";
             if (st == 1 || st == 2 || st == 4 || st == 5) begin
               nx = 0; de = 1; dop = 2;
             end
           end
        default: ;
      endcase
    end else begin
      case (op)
        0: if (st == 0) begin req = "R2"; nx = 3; ue = 1; uo = 0; end
           else if (st == 3 || st == 5) req = "R3";
        2: if (st == 1) begin req = "R4"; de = 1; dop = 3; end
           else if (st == 2) begin req = "R4"; nx = 4; ue = 1; uo = 2; end
        1: if (st == 5) begin req = "R6"; nx = 2; ue = 1; uo = 1; end
        4: if (st == 2) begin
             req = "R9";
             if (flag) begin de = 1; dop = 1; end
             else begin nx = 0; ue = 1; uo = 4; end
           end
        default: ;
      endcase
    end
  endtask

  task automatic apply(input bit above, input int op, input int id,
                       input bit flag);
    int ue, uo, de, dop, nx;
    string req;
    model(above, op, mst[id], flag, ue, uo, de, dop, nx, req);
    @(negedge clk);
    if (above) begin
      up_in_valid = 1; up_in_op = 3'(op); up_in_id = ID_W'(id); up_in_sel = flag;
    end else begin
      lo_in_valid = 1; lo_in_op = 3'(op); lo_in_id = ID_W'(id); lo_in_bid = flag;
    end
    #1;
    if (above)
      chk(up_bid == (op == 0 && (mst[id] == 1 || mst[id] == 2)),
          (req == "R3") ? "R3" : "R5", "bid", int'(up_bid),
          int'(op == 0 && (mst[id] == 1 || mst[id] == 2)));
    chk(above ? up_in_ready : lo_in_ready, "R10", "ready", 0, 1);
    @(negedge clk);
    up_in_valid = 0; lo_in_valid = 0;
    chk(up_out_valid == ue[0] && (!ue || (int'(up_out_op) == uo && int'(up_out_id) == id)),
        req, "upward op", up_out_valid ? int'(up_out_op) : -1, ue ? uo : -1);
    chk(lo_out_valid == de[0] && (!de || (int'(lo_out_op) == dop && int'(lo_out_id) == id)),
        req, "downward op", lo_out_valid ? int'(lo_out_op) : -1, de ? dop : -1);
    mst[id] = nx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    #1;
    chk(!up_out_valid && !lo_out_valid, "R1", "out valids", int'(up_out_valid), 0);
    chk(up_in_ready && lo_in_ready, "R1", "in readys", int'(up_in_ready), 1);
    apply(1, 0, 7, 0);

    // R11: fill all eight ways of set 1, probe a ninth item
    for (int t = 0; t < 8; t++) apply(0, 0, 1 + 4*t, 0);
    for (int t = 0; t < 8; t++) apply(1, 1, 1 + 4*t, 0);
    @(negedge clk);
    up_in_valid = 1; up_in_op = 3'd1; up_in_id = 8'd33;
    @(negedge clk);
    up_in_valid = 0;
    chk(!lo_out_valid && !up_out_valid, "R11", "absent item data", int'(lo_out_valid), 0);
    for (int t = 0; t < 8; t++) apply(1, 0, 1 + 4*t, 0); // all still shared: bid

    // R10: back-pressure and ordering
    do_reset();
    up_out_ready = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lo_in_valid = 1; lo_in_op = 3'd0; lo_in_id = ID_W'(k);
    end
    @(negedge clk);
    lo_in_valid = 0;
    for (int k = 0; k < 4; k++) mst[k] = 3;
    chk(!up_in_ready && !lo_in_ready, "R10", "ready when full", int'(up_in_ready), 0);
    chk(up_out_valid && up_out_id == 0, "R10", "head id", int'(up_out_id), 0);
    repeat (2) @(negedge clk);
    chk(up_out_valid && up_out_id == 0 && up_out_op == 0, "R10", "head held",
        int'(up_out_id), 0);
    up_out_ready = 1;
    for (int k = 0; k < 4; k++) begin
      chk(up_out_valid && int'(up_out_id) == k, "R10", "drain order", int'(up_out_id), k);
      @(negedge clk);
    end
    chk(!up_out_valid, "R10", "drained", int'(up_out_valid), 0);

    // R10: upper side wins when both present
    up_in_valid = 1; up_in_op = 3'd1; up_in_id = 8'd0;
    lo_in_valid = 1; lo_in_op = 3'd0; lo_in_id = 8'd4; lo_in_bid = 0;
    #1;
    chk(up_in_ready && !lo_in_ready, "R10", "priority", int'(lo_in_ready), 0);
    @(negedge clk);
    up_in_valid = 0;
    chk(lo_out_valid && lo_out_op == 1 && lo_out_id == 0, "R6", "data down",
        int'(lo_out_op), 1);
    @(negedge clk);
    lo_in_valid = 0;
    chk(up_out_valid && up_out_op == 0 && up_out_id == 4, "R2", "read up",
        int'(up_out_id), 4);
    @(negedge clk);
    mst[0] = 2; mst[4] = 3;

    // sweep over the state table
    do_reset();
    for (int n = 0; n < 6000; n++)
      apply(bit'($urandom_range(0, 1)), $urandom_range(0, 4),
            $urandom_range(0, NI-1), bit'($urandom_range(0, 1)));

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule